// File: doc/BRIEF.md
# Write-Buffered Three-Port Register File

This block is the register file of a single-issue core that, in every cycle, fetches an instruction word, reads a source operand, reads a destination operand and writes back one result. The storage array has only three ports: two of them can only read, and the third can either read or write. The instruction fetch and the source read each have a read-only port. The destination read and the write-back compete for the shared third port.

The block does not stall the core. Every write-back goes into a small content-addressed write buffer. The buffer commits its oldest entry to the array in any cycle where the shared port is not needed for a destination read. The port is free when the destination read is disabled. It is also free when the destination address is already held in the buffer, because that read is then answered from the buffer. Each of the three reads compares its address against the pending entries and takes the buffered value when it finds a match. As a result, the core sees a consistent view of the register contents with a fixed one-cycle read latency.

If a write-back targets an address that is already pending, it updates that entry instead of taking a new slot. A `buffer_full` output shows that every slot is occupied. While every slot is occupied, a write-back that arrives in a cycle where nothing drains cannot be held.

Top module: `wb_regfile`

## Requirements
- R1: A read presented on the fetch, source or destination port with its enable high returns the register contents on its data output one clock edge later. All three reads and a write-back can be presented in the same cycle. While a port's enable is low, its data output holds its last value.
- R2: A read presented in the same cycle as a write-back to the same address returns the contents from before that write. A read presented in any later cycle returns the written value, whether that value is still buffered or already committed.
- R3: At most DEPTH write-backs are pending. `buffer_full` is registered and is high exactly while DEPTH write-backs are pending.
- R4: A write-back to an address that already has a pending entry replaces that entry's data and does not take another slot. Later reads return the newest data.
- R5: The shared port is free in a cycle when the destination read is disabled or its address matches a pending entry. In every free cycle with a non-empty buffer, the oldest pending entry is committed and its slot is released.
- R6: A write-back to an address with no pending entry is discarded when DEPTH entries are pending and the cycle commits nothing. The register's earlier contents remain readable.
- R7: Synchronous active-high reset empties the buffer, clears `buffer_full` and sets all three read data outputs to zero.
- R8: Under any mix of reads, write-backs, merges, commits and discards, every read returns the value of the last write-back accepted before the cycle in which the read is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_en | input | 1 | Instruction-word read enable |
| fetch_addr | input | ADDR_W | Instruction-word read address |
| fetch_data | output | DATA_W | Instruction word, one cycle after the request |
| src_en | input | 1 | Source-operand read enable |
| src_addr | input | ADDR_W | Source-operand address |
| src_data | output | DATA_W | Source operand, one cycle after the request |
| dst_en | input | 1 | Destination-operand read enable |
| dst_addr | input | ADDR_W | Destination-operand address |
| dst_data | output | DATA_W | Destination operand, one cycle after the request |
| wr_en | input | 1 | Write-back enable |
| wr_addr | input | ADDR_W | Write-back address |
| wr_data | input | DATA_W | Write-back data |
| buffer_full | output | 1 | All write-buffer slots are occupied |

## Verification
The bench builds the block with DEPTH=2 and ADDR_W=6. With only two slots, a run of cycles that keep the shared port busy fills the buffer after two write-backs. The full flag, merges into pending entries and discarded write-backs therefore occur within a few cycles of each other. The random phase confines write-back and destination addresses to an eight-word window. This makes buffer hits, port release on a destination hit, commits in the same cycle as a rewrite of the head entry, and forwarding to all three read ports frequent events rather than rare ones. The 64-word array stays small enough to be fully initialised and mirrored by the reference model.

// File: rtl/wb_regfile_pkg.sv
package wb_regfile_pkg;

  // Operation carried by the shared read/write port of the array in a cycle.
  typedef enum logic [1:0] {
    PC_IDLE  = 2'd0,
    PC_READ  = 2'd1,
    PC_DRAIN = 2'd2
  } portc_op_e;

  localparam int NUM_RD_PORTS = 3;

endpackage

// File: rtl/wb_regfile_array.sv
module wb_regfile_array
  import wb_regfile_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              a_en,
  input  logic [ADDR_W-1:0] a_addr,
  output logic [DATA_W-1:0] a_q,
  input  logic              b_en,
  input  logic [ADDR_W-1:0] b_addr,
  output logic [DATA_W-1:0] b_q,
  input  portc_op_e         c_op,
  input  logic [ADDR_W-1:0] c_addr,
  input  logic [DATA_W-1:0] c_wdata,
  output logic [DATA_W-1:0] c_q
);

  localparam int WORDS = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [WORDS];

  // Only the shared port writes, and only when committing a buffered entry.
  always_ff @(posedge clk) begin
    if (c_op == PC_DRAIN) begin
      mem[c_addr] <= c_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      a_q <= '0;
      b_q <= '0;
      c_q <= '0;
    end else begin
      if (a_en) begin
        a_q <= mem[a_addr];
      end
      if (b_en) begin
        b_q <= mem[b_addr];
      end
      if (c_op == PC_READ) begin
        c_q <= mem[c_addr];
      end
    end
  end

  // R5: a commit cycle does not disturb the shared port's read output.
  assert_drain_keeps_q_R5: assert property (@(posedge clk) disable iff (rst)
    (c_op == PC_DRAIN) |=> $stable(c_q));

endmodule

// File: rtl/wb_regfile_wbuf.sv
module wb_regfile_wbuf #(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 3,
  parameter int NLOOK  = 3
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         wr_en,
  input  logic [ADDR_W-1:0]            wr_addr,
  input  logic [DATA_W-1:0]            wr_data,
  input  logic                         drain,
  input  logic [NLOOK-1:0][ADDR_W-1:0] lk_addr,
  output logic [NLOOK-1:0]             lk_hit,
  output logic [NLOOK-1:0][DATA_W-1:0] lk_data,
  output logic [ADDR_W-1:0]            head_addr,
  output logic [DATA_W-1:0]            head_data,
  output logic                         empty,
  output logic                         full
);

  localparam int CW = $clog2(DEPTH + 1);

  // Slot 0 is the oldest entry; slots below cnt_q are valid.
  logic [ADDR_W-1:0] e_addr [DEPTH];
  logic [DATA_W-1:0] e_data [DEPTH];
  logic [CW-1:0]     cnt_q;
  logic              full_q;

  logic [ADDR_W-1:0] n_addr [DEPTH];
  logic [DATA_W-1:0] n_data [DEPTH];
  logic [CW-1:0]     n_cnt;
  logic              m_hit;
  int                m_idx;

  always_comb begin
    n_addr = e_addr;
    n_data = e_data;
    n_cnt  = cnt_q;
    // Commit of the head: shift everything one slot towards the head.
    if (drain) begin
      for (int i = 0; i < DEPTH - 1; i++) begin
        n_addr[i] = e_addr[i+1];
        n_data[i] = e_data[i+1];
      end
      n_cnt = cnt_q - CW'(1);
    end
    // Merge into a surviving entry with the same address, if any.
    m_hit = 1'b0;
    m_idx = 0;
    if (wr_en) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (CW'(i) < n_cnt && n_addr[i] == wr_addr) begin
          m_hit = 1'b1;
          m_idx = i;
        end
      end
    end
    if (wr_en) begin
      if (m_hit) begin
        for (int i = 0; i < DEPTH; i++) begin
          if (i == m_idx) begin
            n_data[i] = wr_data;
          end
        end
      end else if (n_cnt < CW'(DEPTH)) begin
        for (int i = 0; i < DEPTH; i++) begin
          if (CW'(i) == n_cnt) begin
            n_addr[i] = wr_addr;
            n_data[i] = wr_data;
          end
        end
        n_cnt = n_cnt + CW'(1);
      end
      // Otherwise the buffer is full and nothing drains: the write is dropped.
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      full_q <= 1'b0;
      for (int i = 0; i < DEPTH; i++) begin
        e_addr[i] <= '0;
        e_data[i] <= '0;
      end
    end else begin
      cnt_q  <= n_cnt;
      full_q <= (n_cnt == CW'(DEPTH));
      e_addr <= n_addr;
      e_data <= n_data;
    end
  end

  // Content-addressed lookup, one channel per read port; newest match wins.
  for (genvar g = 0; g < NLOOK; g++) begin : g_look
    logic              h;
    logic [DATA_W-1:0] d;
    always_comb begin
      h = 1'b0;
      d = '0;
      for (int i = 0; i < DEPTH; i++) begin
        if (CW'(i) < cnt_q && e_addr[i] == lk_addr[g]) begin
          h = 1'b1;
          d = e_data[i];
        end
      end
    end
    assign lk_hit[g]  = h;
    assign lk_data[g] = d;
  end

  assign head_addr = e_addr[0];
  assign head_data = e_data[0];
  assign empty     = (cnt_q == '0);
  assign full      = full_q;

  logic dup;
  always_comb begin
    dup = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      for (int j = i + 1; j < DEPTH; j++) begin
        if (CW'(j) < cnt_q && e_addr[i] == e_addr[j]) begin
          dup = 1'b1;
        end
      end
    end
  end

  assert_occ_bound_R3: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CW'(DEPTH));

  assert_full_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (!wr_en && !drain) |=> $stable(full_q));

  assert_unique_R4: assert property (@(posedge clk) disable iff (rst)
    !dup);

  assert_drain_nonempty_R5: assert property (@(posedge clk) disable iff (rst)
    drain |-> (cnt_q != '0));

  assert_drain_release_R5: assert property (@(posedge clk) disable iff (rst)
    (drain && !wr_en) |=> (cnt_q == $past(cnt_q) - CW'(1)));

endmodule

// File: rtl/wb_regfile_fwd.sv
module wb_regfile_fwd #(
  parameter int DATA_W = 32,
  parameter int NP     = 3
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NP-1:0]             rd_en,
  input  logic [NP-1:0]             hit,
  input  logic [NP-1:0][DATA_W-1:0] buf_data,
  input  logic [NP-1:0][DATA_W-1:0] arr_q,
  output logic [NP-1:0][DATA_W-1:0] rd_data
);

  for (genvar p = 0; p < NP; p++) begin : g_port
    logic              hit_q;
    logic [DATA_W-1:0] data_q;

    // Buffer match is captured in the request cycle, alongside the array read.
    always_ff @(posedge clk) begin
      if (rst) begin
        hit_q  <= 1'b0;
        data_q <= '0;
      end else if (rd_en[p]) begin
        hit_q  <= hit[p];
        data_q <= buf_data[p];
      end
    end

    assign rd_data[p] = hit_q ? data_q : arr_q[p];

    assert_idle_hold_R1: assert property (@(posedge clk) disable iff (rst)
      !rd_en[p] |=> $stable(rd_data[p]));
  end

endmodule

// File: rtl/wb_regfile.sv
module wb_regfile
  import wb_regfile_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fetch_en,
  input  logic [ADDR_W-1:0] fetch_addr,
  output logic [DATA_W-1:0] fetch_data,
  input  logic              src_en,
  input  logic [ADDR_W-1:0] src_addr,
  output logic [DATA_W-1:0] src_data,
  input  logic              dst_en,
  input  logic [ADDR_W-1:0] dst_addr,
  output logic [DATA_W-1:0] dst_data,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              buffer_full
);

  localparam int NP = NUM_RD_PORTS;

  logic [NP-1:0][ADDR_W-1:0] lk_addr;
  logic [NP-1:0]             lk_hit;
  logic [NP-1:0][DATA_W-1:0] lk_data;
  logic [NP-1:0][DATA_W-1:0] arr_q;
  logic [NP-1:0][DATA_W-1:0] rd_data;
  logic [NP-1:0]             rd_en;
  logic [ADDR_W-1:0]         head_addr;
  logic [DATA_W-1:0]         head_data;
  logic                      buf_empty;
  logic                      portc_busy;
  logic                      drain;
  portc_op_e                 c_op;
  logic [ADDR_W-1:0]         c_addr;

  assign lk_addr = {dst_addr, src_addr, fetch_addr};
  assign rd_en   = {dst_en, src_en, fetch_en};

  // Shared port arbitration: a destination read answered by the buffer
  // leaves the port free for a commit.
  assign portc_busy = dst_en && !lk_hit[2];
  assign drain      = !portc_busy && !buf_empty;

  always_comb begin
    if (portc_busy) begin
      c_op   = PC_READ;
      c_addr = dst_addr;
    end else if (drain) begin
      c_op   = PC_DRAIN;
      c_addr = head_addr;
    end else begin
      c_op   = PC_IDLE;
      c_addr = head_addr;
    end
  end

  wb_regfile_array #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) array_i (
    .clk     (clk),
    .rst     (rst),
    .a_en    (fetch_en),
    .a_addr  (fetch_addr),
    .a_q     (arr_q[0]),
    .b_en    (src_en),
    .b_addr  (src_addr),
    .b_q     (arr_q[1]),
    .c_op    (c_op),
    .c_addr  (c_addr),
    .c_wdata (head_data),
    .c_q     (arr_q[2])
  );

  wb_regfile_wbuf #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .DEPTH  (DEPTH),
    .NLOOK  (NP)
  ) wbuf_i (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .drain     (drain),
    .lk_addr   (lk_addr),
    .lk_hit    (lk_hit),
    .lk_data   (lk_data),
    .head_addr (head_addr),
    .head_data (head_data),
    .empty     (buf_empty),
    .full      (buffer_full)
  );

  wb_regfile_fwd #(
    .DATA_W (DATA_W),
    .NP     (NP)
  ) fwd_i (
    .clk      (clk),
    .rst      (rst),
    .rd_en    (rd_en),
    .hit      (lk_hit),
    .buf_data (lk_data),
    .arr_q    (arr_q),
    .rd_data  (rd_data)
  );

  assign fetch_data = rd_data[0];
  assign src_data   = rd_data[1];
  assign dst_data   = rd_data[2];

endmodule

// File: tb/wb_regfile_tb_top.sv
module wb_regfile_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int TB_AW      = 6;
  localparam int TB_DW      = 32;
  localparam int TB_DEPTH   = 2;
  localparam int WORDS      = 1 << TB_AW;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             fetch_en = 1'b0, src_en = 1'b0, dst_en = 1'b0, wr_en = 1'b0;
  logic [TB_AW-1:0] fetch_addr = '0, src_addr = '0, dst_addr = '0, wr_addr = '0;
  logic [TB_DW-1:0] wr_data = '0;
  logic [TB_DW-1:0] fetch_data, src_data, dst_data;
  logic             buffer_full;

  always #(CLK_PERIOD/2) clk = ~clk;

  wb_regfile #(
    .ADDR_W (TB_AW),
    .DATA_W (TB_DW),
    .DEPTH  (TB_DEPTH)
  ) dut_i (
    .clk         (clk),
    .rst         (rst),
    .fetch_en    (fetch_en),
    .fetch_addr  (fetch_addr),
    .fetch_data  (fetch_data),
    .src_en      (src_en),
    .src_addr    (src_addr),
    .src_data    (src_data),
    .dst_en      (dst_en),
    .dst_addr    (dst_addr),
    .dst_data    (dst_data),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .buffer_full (buffer_full)
  );

  typedef struct {
    int          due;
    int          kind;
    logic [31:0] exp;
    string       req;
  } item_t;

  item_t       sbq[$];
  int          pend[$];
  logic [31:0] model [WORDS];
  int          checks = 0;
  int          errors = 0;
  int          edge_cnt = 0;

  always @(posedge clk) edge_cnt <= edge_cnt + 1;

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic bit is_pending(int a);
    foreach (pend[i]) if (pend[i] == a) return 1'b1;
    return 1'b0;
  endfunction

  // Monitor: compares each output against the scoreboard when it is due.
  always @(negedge clk) begin
    while (sbq.size() > 0 && sbq[0].due <= edge_cnt) begin
      item_t it;
      it = sbq.pop_front();
      case (it.kind)
        0: check(it.req, "fetch_data", fetch_data, it.exp);
        1: check(it.req, "src_data", src_data, it.exp);
        2: check(it.req, "dst_data", dst_data, it.exp);
        default: check("R3", "buffer_full", {31'b0, buffer_full}, it.exp);
      endcase
    end
  end

  // Driver: applies one cycle of stimulus and pushes the expected results.
  task automatic step(bit fe, int fa, bit se, int sa, bit de, int da,
                      bit we, int wa, logic [31:0] wd, string req);
    bit free;
    @(posedge clk);
    #1;
    fetch_en = fe; fetch_addr = TB_AW'(fa);
    src_en   = se; src_addr   = TB_AW'(sa);
    dst_en   = de; dst_addr   = TB_AW'(da);
    wr_en    = we; wr_addr    = TB_AW'(wa); wr_data = wd;
    if (fe) sbq.push_back('{edge_cnt + 1, 0, model[fa], req});
    if (se) sbq.push_back('{edge_cnt + 1, 1, model[sa], req});
    if (de) sbq.push_back('{edge_cnt + 1, 2, model[da], req});
    // R5: port free when no destination read or the read hits the buffer.
    free = !de || is_pending(da);
    if (free && pend.size() > 0) void'(pend.pop_front());
    if (we) begin
      if (is_pending(wa)) begin
        model[wa] = wd;                       // R4 merge
      end else if (pend.size() < TB_DEPTH) begin
        pend.push_back(wa);
        model[wa] = wd;
      end                                     // else R6 discard
    end
    sbq.push_back('{edge_cnt + 1, 3, {31'b0, pend.size() == TB_DEPTH}, "R3"});
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) step(0, 0, 0, 0, 0, 0, 0, 0, '0, "R5");
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL R1 watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int a = 0; a < WORDS; a++) model[a] = '0;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // R7: reset state.
    check("R7", "fetch_data", fetch_data, '0);
    check("R7", "src_data", src_data, '0);
    check("R7", "dst_data", dst_data, '0);
    check("R7", "buffer_full", {31'b0, buffer_full}, '0);

    // Fill every word; destination port idle so commits keep pace.
    for (int a = 0; a < WORDS; a++)
      step(0, 0, 0, 0, 0, 0, 1, a, 32'hA5A5_0000 ^ (a * 32'h0101_0101), "R1");
    idle(2);

    // R1: three reads alongside a write-back.
    step(1, 3, 1, 7, 1, 9, 1, 20, 32'h1111_2020, "R1");
    step(1, 20, 1, 9, 1, 3, 1, 21, 32'h2222_2121, "R1");
    step(1, 21, 1, 20, 1, 63, 0, 0, '0, "R1");
    // R1: idle enables hold outputs (checked by comparing with prior value).
    step(0, 0, 0, 0, 0, 0, 0, 0, '0, "R1");
    sbq.push_back('{edge_cnt + 1, 0, model[21], "R1"});
    sbq.push_back('{edge_cnt + 1, 1, model[20], "R1"});
    sbq.push_back('{edge_cnt + 1, 2, model[63], "R1"});
    idle(2);

    // R2: same-cycle read sees prior contents, next cycle sees new.
    step(1, 5, 1, 5, 1, 5, 1, 5, 32'hDEAD_0005, "R2");
    step(1, 5, 1, 5, 1, 5, 0, 0, '0, "R2");
    idle(2);

    // R3/R4/R6: keep the shared port busy with a non-pending destination.
    step(0, 0, 0, 0, 1, 40, 1, 10, 32'h0000_AAAA, "R3");
    step(0, 0, 0, 0, 1, 40, 1, 11, 32'h0000_BBBB, "R3");
    step(1, 10, 0, 0, 1, 40, 1, 10, 32'h0000_CCCC, "R4");
    step(0, 0, 0, 0, 1, 40, 1, 12, 32'h0000_DDDD, "R6");
    step(1, 12, 1, 10, 1, 40, 0, 0, '0, "R6");
    step(1, 11, 1, 10, 1, 40, 0, 0, '0, "R4");
    // R5: destination hit frees the port; the head commits.
    step(0, 0, 0, 0, 1, 10, 0, 0, '0, "R5");
    step(1, 10, 1, 11, 1, 11, 0, 0, '0, "R5");
    idle(3);
    step(1, 10, 1, 11, 1, 12, 0, 0, '0, "R5");

    // R8: random traffic in a narrow address window.
    for (int n = 0; n < 4000; n++) begin
      step($urandom_range(0, 3) != 0, $urandom_range(0, 9),
           $urandom_range(0, 3) != 0, $urandom_range(0, 9),
           $urandom_range(0, 3) != 0, $urandom_range(0, 7),
           $urandom_range(0, 6) != 0, $urandom_range(0, 7),
           $urandom(), "R8");
    end
    idle(3);
    @(negedge clk);
    @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule